// File: doc/BRIEF.md
# Page-Aware Burst Write DMA

This block writes a contiguous region of memory over AXI4 on its own. It takes a start address and a byte count on a small command port, pulls words from a valid/ready source stream, and turns the region into a series of INCR write bursts. Each burst is made as long as the rules allow. The limits are 256 beats, the beats still left to send, and the beats left before the next 4 KB page edge. Data always fills the whole bus, so every beat has all strobes set.

The block can post several bursts on the address channel before earlier ones have been acknowledged, up to a configurable number. A short queue of burst lengths keeps the data channel in step with the addresses already issued, so each burst ends with its last flag on the correct beat. The engine accepts no new command until every write response has returned. It then gives a one-cycle completion pulse. Any non-OKAY response sets a sticky error flag, and the next accepted command clears it. A command whose address or length is not a whole number of bus words, or whose length is zero, is refused with a one-cycle reject pulse and starts no traffic.

Top module: `axi_burst_wdma`

## Requirements
- R1: Every address phase uses burst type INCR (awburst = 2'b01) and a beat size equal to the bus width (awsize = 2 for a 32-bit bus). Every data beat has all write strobes set.
- R2: No burst carries more than 256 beats, so awlen never exceeds 255.
- R3: No burst crosses a 4096-byte address boundary: (awaddr mod 4096) + (awlen+1)*4 is at most 4096.
- R4: Bursts cover the command region in ascending address order with no gaps. Each burst length equals the minimum of 256, the beats remaining, and the beats before the next 4 KB boundary. This gives a known burst count per command.
- R5: Each burst carries exactly awlen+1 data beats, and wlast is high on the final beat only.
- R6: Once raised, awvalid holds with awaddr and awlen unchanged until awready. No data beat is offered for a burst whose address handshake has not yet happened.
- R7: The number of bursts whose address was accepted but whose response has not returned never exceeds MAX_OUT (4 by default). awvalid stays low while that count equals MAX_OUT, and new bursts are issued while earlier responses are still pending.
- R8: Source words reach wdata in order, with none lost or repeated under wready backpressure. wvalid is low whenever src_valid is low.
- R9: A command with address or byte count not a multiple of 4, or with a byte count of zero, produces a one-cycle cmd_reject pulse in the cycle after acceptance. No address phase follows, and cmd_ready stays high.
- R10: cmd_ready is low from the cycle after a valid command is accepted until completion. done is a single-cycle pulse in the cycle after the last write response handshake.
- R11: A response with bresp other than 2'b00 sets resp_err. resp_err stays set until the next command is accepted, which clears it.
- R12: During and right after reset, cmd_ready is high and awvalid, wvalid, done, cmd_reject and resp_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_bytes | input | BYTES_W | Number of bytes to write |
| cmd_reject | output | 1 | One-cycle pulse: command refused |
| done | output | 1 | One-cycle pulse: all responses returned |
| resp_err | output | 1 | Sticky flag: a non-OKAY response was seen |
| src_valid | input | 1 | Source word available |
| src_ready | output | 1 | Source word consumed |
| src_data | input | DATA_W | Source word |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Beats in burst minus one |
| awsize | output | 3 | Log2 of bytes per beat |
| awburst | output | 2 | Burst type (INCR) |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes, all set |
| wlast | output | 1 | Final beat of burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |

## Verification
The table of commands separates the three burst-length limits. Some regions fit in one short burst. Some end exactly at or one word past 256 beats, which splits on the beat limit. Some start a few words below a page edge, which splits on the page limit. One starts off page alignment with more than 256 beats, which splits on both. The largest command needs more bursts than the outstanding limit, and the memory model holds back responses until the limit is reached, so an engine that ignores the limit or issues only one burst at a time shows up in the burst count and the stall check. Random ready and valid gaps on every channel expose lost, repeated or misplaced beats. Directed runs cover the three reject reasons and the set and clear of the response error flag.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

    localparam int unsigned PAGE_BYTES = 4096;
    localparam int unsigned BURST_MAX  = 256;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10
    } burst_kind_e;

    typedef enum logic [1:0] {
        RS_OKAY   = 2'b00,
        RS_EXOKAY = 2'b01,
        RS_SLVERR = 2'b10,
        RS_DECERR = 2'b11
    } resp_code_e;

    // Beats of the next burst: smallest of the hard cap, the work left
    // and the room up to the next page edge.
    function automatic logic [8:0] burst_beats(input logic [11:0] page_off,
                                               input logic [31:0] left,
                                               input int unsigned shift);
        logic [12:0] room;
        logic [31:0] n;
        room = 13'(13'd4096 - {1'b0, page_off}) >> shift;
        n = left;
        if (n > BURST_MAX) n = BURST_MAX;
        if ({19'd0, room} < n) n = {19'd0, room};
        return n[8:0];
    endfunction

endpackage

// File: rtl/wdma_addr_gen.sv
module wdma_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int BEATS_W    = 18,
    parameter int BEAT_SHIFT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [BEATS_W-1:0] load_beats,
    input  logic               can_issue,
    input  logic               awready,
    output logic               awvalid,
    output logic [ADDR_W-1:0]  awaddr,
    output logic [7:0]         awlen,
    output logic               aw_fire,
    output logic               all_issued
);
    import wdma_pkg::*;

    logic [ADDR_W-1:0]  cur_addr;
    logic [BEATS_W-1:0] left;
    logic [8:0]         len9;

    assign len9       = burst_beats(cur_addr[11:0], 32'(left), BEAT_SHIFT);
    assign all_issued = (left == '0);
    assign awvalid    = !all_issued && can_issue;
    assign awaddr     = cur_addr;
    assign awlen      = 8'(len9 - 9'd1);
    assign aw_fire    = awvalid && awready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            left     <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            left     <= load_beats;
        end else if (aw_fire) begin
            cur_addr <= cur_addr + (ADDR_W'(len9) << BEAT_SHIFT);
            left     <= left - BEATS_W'(len9);
        end
    end
endmodule

// File: rtl/wdma_len_fifo.sv
module wdma_len_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) wr_ptr <= step(wr_ptr);
            if (pop && !empty) rd_ptr <= step(rd_ptr);
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wdma_wbeat.sv
module wdma_wbeat (
    input  logic       clk,
    input  logic       rst,
    input  logic       q_empty,
    input  logic [7:0] q_len,
    input  logic       src_valid,
    input  logic       wready,
    output logic       src_ready,
    output logic       wvalid,
    output logic       wlast,
    output logic       pop
);
    logic [7:0] beat_cnt;
    logic       w_fire;

    assign wvalid    = !q_empty && src_valid;
    assign src_ready = !q_empty && wready;
    assign wlast     = !q_empty && (beat_cnt == q_len);
    assign w_fire    = wvalid && wready;
    assign pop       = w_fire && wlast;

    always_ff @(posedge clk) begin
        if (rst)          beat_cnt <= '0;
        else if (pop)     beat_cnt <= '0;
        else if (w_fire)  beat_cnt <= beat_cnt + 1'b1;
    end
endmodule

// File: rtl/wdma_resp_track.sv
module wdma_resp_track #(
    parameter int MAX_OUT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       aw_fire,
    input  logic       bvalid,
    input  logic [1:0] bresp,
    input  logic       busy,
    input  logic       all_issued,
    input  logic       clear_err,
    output logic       bready,
    output logic       can_issue,
    output logic       last_b,
    output logic       done,
    output logic       resp_err
);
    import wdma_pkg::*;

    localparam int OUT_W = $clog2(MAX_OUT + 1);

    logic [OUT_W-1:0] out_cnt;
    logic             b_fire;

    assign bready    = 1'b1;
    assign b_fire    = bvalid && bready;
    assign can_issue = (out_cnt < OUT_W'(MAX_OUT));
    assign last_b    = b_fire && busy && all_issued && (out_cnt == OUT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_cnt  <= '0;
            done     <= 1'b0;
            resp_err <= 1'b0;
        end else begin
            case ({aw_fire, b_fire && (out_cnt != '0)})
                2'b10:   out_cnt <= out_cnt + 1'b1;
                2'b01:   out_cnt <= out_cnt - 1'b1;
                default: out_cnt <= out_cnt;
            endcase
            done <= last_b;
            if (clear_err)
                resp_err <= 1'b0;
            else if (b_fire && (bresp != RS_OKAY))
                resp_err <= 1'b1;
        end
    end
endmodule

// File: rtl/axi_burst_wdma.sv
module axi_burst_wdma #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BYTES_W = 20,
    parameter int MAX_OUT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [BYTES_W-1:0]  cmd_bytes,
    output logic                cmd_reject,
    output logic                done,
    output logic                resp_err,
    input  logic                src_valid,
    output logic                src_ready,
    input  logic [DATA_W-1:0]   src_data,
    output logic                awvalid,
    input  logic                awready,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [7:0]          awlen,
    output logic [2:0]          awsize,
    output logic [1:0]          awburst,
    output logic                wvalid,
    input  logic                wready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast,
    input  logic                bvalid,
    output logic                bready,
    input  logic [1:0]          bresp
);
    import wdma_pkg::*;

    localparam int STRB_W     = DATA_W / 8;
    localparam int BEAT_SHIFT = $clog2(STRB_W);
    localparam int BEATS_W    = BYTES_W - BEAT_SHIFT;

    logic busy;
    logic cmd_fire, cmd_ok, load;
    logic aw_fire, all_issued, can_issue, aw_can;
    logic q_empty, q_full, q_pop;
    logic [7:0] q_len;
    logic last_b;

    assign cmd_ready = !busy;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign cmd_ok    = ((cmd_addr & ADDR_W'(STRB_W - 1)) == '0) &&
                       ((cmd_bytes & BYTES_W'(STRB_W - 1)) == '0) &&
                       (cmd_bytes != '0);
    assign load      = cmd_fire && cmd_ok;
    assign aw_can    = can_issue && !q_full;

    assign awsize  = 3'(BEAT_SHIFT);
    assign awburst = BT_INCR;
    assign wstrb   = '1;
    assign wdata   = src_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_reject <= cmd_fire && !cmd_ok;
            if (load)        busy <= 1'b1;
            else if (last_b) busy <= 1'b0;
        end
    end

    wdma_addr_gen #(
        .ADDR_W(ADDR_W), .BEATS_W(BEATS_W), .BEAT_SHIFT(BEAT_SHIFT)
    ) u_addr (
        .clk(clk), .rst(rst),
        .load(load), .load_addr(cmd_addr),
        .load_beats(cmd_bytes[BYTES_W-1:BEAT_SHIFT]),
        .can_issue(aw_can), .awready(awready),
        .awvalid(awvalid), .awaddr(awaddr), .awlen(awlen),
        .aw_fire(aw_fire), .all_issued(all_issued)
    );

    wdma_len_fifo #(.DEPTH(MAX_OUT), .W(8)) u_lenq (
        .clk(clk), .rst(rst),
        .push(aw_fire), .push_data(awlen),
        .pop(q_pop), .head(q_len),
        .empty(q_empty), .full(q_full)
    );

    wdma_wbeat u_wbeat (
        .clk(clk), .rst(rst),
        .q_empty(q_empty), .q_len(q_len),
        .src_valid(src_valid), .wready(wready),
        .src_ready(src_ready), .wvalid(wvalid),
        .wlast(wlast), .pop(q_pop)
    );

    wdma_resp_track #(.MAX_OUT(MAX_OUT)) u_resp (
        .clk(clk), .rst(rst),
        .aw_fire(aw_fire), .bvalid(bvalid), .bresp(bresp),
        .busy(busy), .all_issued(all_issued), .clear_err(cmd_fire),
        .bready(bready), .can_issue(can_issue),
        .last_b(last_b), .done(done), .resp_err(resp_err)
    );
endmodule

// File: rtl/wdma_chk.sv
module wdma_chk #(
    parameter int ADDR_W     = 32,
    parameter int MAX_OUT    = 4,
    parameter int BEAT_SHIFT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_ready,
    input logic              cmd_reject,
    input logic              done,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [7:0]        awlen,
    input logic [1:0]        awburst,
    input logic              wvalid,
    input logic              src_valid,
    input logic              bvalid,
    input logic              bready
);
    logic [7:0] ck_out;

    always_ff @(posedge clk) begin
        if (rst) ck_out <= '0;
        else if ((awvalid && awready) && !(bvalid && bready)) ck_out <= ck_out + 1'b1;
        else if (!(awvalid && awready) && (bvalid && bready) && ck_out != '0)
            ck_out <= ck_out - 1'b1;
    end

    // R1
    aw_incr_chk: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> awburst == 2'b01);

    // R3
    page_edge_chk: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> ({4'd0, awaddr[11:0]} + ((16'(awlen) + 16'd1) << BEAT_SHIFT)) <= 16'd4096);

    // R6
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ck_out <= 8'(MAX_OUT));

    // R7
    aw_stall_chk: assert property (@(posedge clk) disable iff (rst)
        ck_out == 8'(MAX_OUT) |-> !awvalid);

    // R8
    w_src_chk: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> src_valid);

    // R9
    reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> cmd_ready);

    // R10
    done_after_b_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bvalid && bready));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind axi_burst_wdma wdma_chk #(
    .ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT), .BEAT_SHIFT(BEAT_SHIFT)
) u_chk (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .cmd_reject(cmd_reject),
    .done(done), .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .awlen(awlen), .awburst(awburst), .wvalid(wvalid), .src_valid(src_valid),
    .bvalid(bvalid), .bready(bready)
);

// File: tb/tb_axi_burst_wdma.sv
module tb_axi_burst_wdma;
    localparam int MAX_OUT = 4;

    typedef struct packed {
        logic [31:0] addr;
        logic [19:0] bytes;
        logic [7:0]  nbursts;
        logic [7:0]  first_len;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 20'd16,   8'd1, 8'd3},
        '{32'h0000_1000, 20'd1024, 8'd1, 8'd255},
        '{32'h0000_1000, 20'd1028, 8'd2, 8'd255},
        '{32'h0000_1FF0, 20'd64,   8'd2, 8'd3},
        '{32'h0000_2C00, 20'd4096, 8'd4, 8'd255},
        '{32'h0000_0FFC, 20'd8,    8'd2, 8'd0},
        '{32'h0000_5004, 20'd2048, 8'd2, 8'd255},
        '{32'h0000_7000, 20'd4,    8'd1, 8'd0},
        '{32'h0000_8000, 20'd6144, 8'd6, 8'd255}
    };

    logic clk = 1'b0;
    logic rst;
    logic cmd_valid, cmd_ready, cmd_reject, done, resp_err;
    logic [31:0] cmd_addr;
    logic [19:0] cmd_bytes;
    logic src_valid, src_ready;
    logic [31:0] src_data;
    logic awvalid, awready;
    logic [31:0] awaddr;
    logic [7:0] awlen;
    logic [2:0] awsize;
    logic [1:0] awburst;
    logic wvalid, wready, wlast;
    logic [31:0] wdata;
    logic [3:0] wstrb;
    logic bvalid, bready;
    logic [1:0] bresp;

    always #2.5 clk = ~clk;

    axi_burst_wdma #(.ADDR_W(32), .DATA_W(32), .BYTES_W(20), .MAX_OUT(MAX_OUT)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_reject(cmd_reject),
        .done(done), .resp_err(resp_err), .src_valid(src_valid),
        .src_ready(src_ready), .src_data(src_data), .awvalid(awvalid),
        .awready(awready), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
        .awburst(awburst), .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .wstrb(wstrb), .wlast(wlast), .bvalid(bvalid), .bready(bready),
        .bresp(bresp)
    );

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;
    int wd_fail = 0;
    bit mon_on = 0;
    bit inj_err = 0;

    // memory-side model state (owned by monitor)
    int exp_addr = 0, exp_left = 0;
    int tb_out = 0, max_out = 0, pending_b = 0, aw_seen = 0;
    int first_len = -1;
    bit first_pend = 0;
    int q_len [64];
    int q_wr = 0, q_rd = 0, q_cnt = 0, beat = 0;
    int src_cnt = 0, w_exp = 0;

    task automatic mchk(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            awready   = ($urandom % 4) != 0;
            wready    = ($urandom % 4) != 0;
            src_valid = ($urandom % 5) != 0;
            src_data  = src_cnt;
            bvalid    = (pending_b > 0) && ((tb_out == MAX_OUT) || (exp_left == 0)) &&
                        (($urandom % 2) != 0);
            bresp     = inj_err ? 2'b10 : 2'b00;
            #1;
            if (cmd_valid && cmd_ready && cmd_addr[1:0] == 0 && cmd_bytes[1:0] == 0 &&
                cmd_bytes != 0) begin
                exp_addr   = cmd_addr;
                exp_left   = cmd_bytes / 4;
                first_pend = 1;
            end
            if (tb_out == MAX_OUT)
                mchk(!awvalid, "R7", "awvalid at outstanding limit", awvalid, 0);
            if (awvalid && awready) begin
                int len, room;
                len  = (exp_left > 256) ? 256 : exp_left;
                room = (4096 - (exp_addr % 4096)) / 4;
                if (room < len) len = room;
                mchk(exp_left > 0, "R4", "extra burst, beats left", exp_left, 1);
                mchk(awaddr == exp_addr, "R4", "awaddr", awaddr, exp_addr);
                mchk(awlen == len - 1, "R2", "awlen", awlen, len - 1);
                mchk(awburst == 2'b01 && awsize == 3'd2, "R1", "burst/size",
                     {awburst, awsize}, 5'b01010);
                mchk((awaddr % 4096) + (awlen + 1) * 4 <= 4096, "R3", "page end",
                     (awaddr % 4096) + (awlen + 1) * 4, 4096);
                if (first_pend) begin first_len = awlen; first_pend = 0; end
                q_len[q_wr] = awlen; q_wr = (q_wr + 1) % 64; q_cnt++;
                exp_addr += len * 4; exp_left -= len;
                tb_out++; aw_seen++;
                if (tb_out > max_out) max_out = tb_out;
            end
            if (wvalid)
                mchk(src_valid, "R8", "wvalid without source", wvalid, 0);
            if (wvalid && wready) begin
                mchk(q_cnt > 0, "R6", "beat before address", q_cnt, 1);
                mchk(wdata == w_exp, "R8", "wdata order", wdata, w_exp);
                mchk(wstrb == 4'hF, "R1", "wstrb", wstrb, 15);
                if (q_cnt > 0)
                    mchk(wlast == (beat == q_len[q_rd]), "R5", "wlast position",
                         wlast, beat == q_len[q_rd]);
                w_exp++;
                if (wlast) begin
                    beat = 0; pending_b++;
                    if (q_cnt > 0) begin q_rd = (q_rd + 1) % 64; q_cnt--; end
                end else beat++;
            end
            if (src_valid && src_ready) src_cnt++;
            if (bvalid && bready) begin pending_b--; tb_out--; end
        end
    end

    task automatic run_cmd(input logic [31:0] a, input logic [19:0] b, input bit exp_rej,
                           input int exp_bursts, input int exp_first);
        int base, wait_n;
        @(negedge clk);
        cmd_valid = 1; cmd_addr = a; cmd_bytes = b;
        base = aw_seen;
        @(negedge clk);
        cmd_valid = 0;
        chk(cmd_reject == exp_rej, exp_rej ? "R9" : "R10", "cmd_reject", cmd_reject, exp_rej);
        if (exp_rej) begin
            repeat (10) @(negedge clk);
            chk(aw_seen == base, "R9", "bursts after reject", aw_seen - base, 0);
            chk(cmd_ready == 1 && cmd_reject == 0, "R9", "idle after reject", cmd_ready, 1);
        end else begin
            chk(cmd_ready == 0, "R10", "cmd_ready while busy", cmd_ready, 0);
            wait_n = 0;
            while (!done && wait_n < 20000) begin @(negedge clk); wait_n++; end
            chk(done == 1, "R10", "done seen", done, 1);
            chk(tb_out == 0 && pending_b == 0 && exp_left == 0, "R10",
                "responses left at done", tb_out + pending_b, 0);
            chk(aw_seen - base == exp_bursts, "R4", "burst count", aw_seen - base, exp_bursts);
            chk(first_len == exp_first, "R4", "first awlen", first_len, exp_first);
            chk(q_cnt == 0 && beat == 0, "R5", "beats left in burst", q_cnt, 0);
            @(negedge clk);
            chk(done == 0, "R10", "done one cycle", done, 0);
            chk(cmd_ready == 1, "R10", "ready after done", cmd_ready, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        wd_fail = 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + m_chk - n_fail - m_fail,
                 n_chk + m_chk + 1);
        $finish;
    end

    initial begin
        rst = 1; cmd_valid = 0; cmd_addr = 0; cmd_bytes = 0;
        src_valid = 0; src_data = 0; awready = 0; wready = 0; bvalid = 0; bresp = 0;
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(cmd_ready == 1, "R12", "cmd_ready in reset", cmd_ready, 1);
        chk(!awvalid && !wvalid, "R12", "channels idle in reset", awvalid + wvalid, 0);
        chk(!done && !cmd_reject && !resp_err, "R12", "flags in reset",
            done + cmd_reject + resp_err, 0);
        rst = 0;
        @(negedge clk);
        chk(cmd_ready == 1 && !awvalid && !done, "R12", "state after reset", cmd_ready, 1);
        mon_on = 1;

        for (int i = 0; i < NV; i++)
            run_cmd(VECS[i].addr, VECS[i].bytes, 0, VECS[i].nbursts, VECS[i].first_len);
        chk(max_out == MAX_OUT, "R7", "peak outstanding", max_out, MAX_OUT);
        chk(resp_err == 0, "R11", "no error on clean runs", resp_err, 0);

        // R9 rejected commands
        run_cmd(32'h1002, 20'd16, 1, 0, 0);
        run_cmd(32'h1000, 20'd0,  1, 0, 0);
        run_cmd(32'h1000, 20'd6,  1, 0, 0);

        // R11 sticky error and clearing
        inj_err = 1;
        run_cmd(32'h9000, 20'd32, 0, 1, 7);
        inj_err = 0;
        chk(resp_err == 1, "R11", "error set after SLVERR", resp_err, 1);
        repeat (5) @(negedge clk);
        chk(resp_err == 1, "R11", "error stays set", resp_err, 1);
        run_cmd(32'hA000, 20'd16, 0, 1, 3);
        chk(resp_err == 0, "R11", "error cleared by new command", resp_err, 0);

        $display("%0d/%0d checks passed", n_chk + m_chk - n_fail - m_fail - wd_fail,
                 n_chk + m_chk + wd_fail);
        $finish;
    end
endmodule